// File: doc/BRIEF.md
# Root Clock Source Sequencer

This block controls the root clock sources of a chip and decides which one drives the system clock. Software writes a small set of fields: enables for the fast external oscillator and the PLL, the PLL reference and multiplier, the requested system source, the real-time clock source and the USB prescale. The block returns ready flags, the active system source, a switch-status code and the frequencies that follow from the current settings, in kHz.

Oscillator start-up and PLL lock are modelled as counters, so the switching rules can be checked without analog models. A source switch takes effect only when the requested source is ready. PLL settings are frozen while the PLL is enabled. Sources that are in use cannot be turned off.

Writes use one strobe, a 3-bit field address and a 6-bit data word. Address 0 holds the enables, 1 the PLL setup, 2 the system request, 3 the real-time clock select and 4 the USB prescale. Each write takes effect at the clock edge that samples it.

Top module: `clk_seq_top`

## Requirements
- R1: During and after reset, the active source is the fast internal clock (sys_sel_o=0, sws_o=0), both ready flags are low, rtc_sel_o=0, pll_ref_o=0 and pll_mul_o=2.
- R2: A write to address 0 with bit 0 set enables the external oscillator. xosc_rdy_o rises XOSC_START_CYC clock edges after the edge that takes the write. It falls right after an accepted disable.
- R3: A write to address 0 with bit 1 set enables the PLL. pll_rdy_o rises after PLL_LOCK_CYC counted edges. An edge is counted only while the PLL is enabled and its reference is available: the internal reference always, an external reference only while xosc_rdy_o is high. pll_rdy_o falls right after an accepted disable.
- R4: A write to address 1 is ignored while the PLL is enabled. A write to address 1 with reference code 3 is also ignored.
- R5: Address 1 bits [1:0] select the PLL reference: 0 gives FINT_KHZ/2, 1 gives FEXT_KHZ, 2 gives FEXT_KHZ/2. Bits [5:2] hold a code c, and the multiplier is min(c+2,16). pll_mul_o shows the multiplier and pll_khz_o shows reference×multiplier.
- R6: pll_bad_o is high when pll_khz_o exceeds PLL_MAX_KHZ. While it is high, a PLL enable request is ignored.
- R7: Address 2 bits [1:0] request a system source: 0 internal, 1 external, 2 PLL. Code 3 is ignored. sys_sel_o takes the requested code at the first edge after the request at which that source is ready. Until then it keeps the previous source.
- R8: sws_o reads 0x0, 0x4 or 0x8 when the active source is internal, external or PLL.
- R9: A disable of the PLL while it is the active source is ignored. A disable of the external oscillator is ignored while it is the active source, or while the PLL is enabled with an external reference.
- R10: Address 3 bits [1:0] set rtc_sel_o: 0 none, 1 slow external, 2 slow internal, 3 fast external/128.
- R11: Address 4 bit 0 sets the USB prescale: 0 gives usb_khz_o = pll_khz_o, 1 gives usb_khz_o = floor(2·pll_khz_o/3).
- R12: sys_khz_o equals FINT_KHZ, FEXT_KHZ or pll_khz_o, following the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Field address |
| wr_data_i | input | 6 | Write data |
| xosc_rdy_o | output | 1 | External oscillator ready |
| pll_rdy_o | output | 1 | PLL locked |
| sys_sel_o | output | 2 | Active system source code |
| sws_o | output | 4 | Switch-status code |
| rtc_sel_o | output | 2 | Real-time clock source code |
| pll_ref_o | output | 2 | Stored PLL reference code |
| pll_mul_o | output | 5 | PLL multiplier value |
| pll_bad_o | output | 1 | PLL output over the limit |
| pll_khz_o | output | KHZ_W | PLL output frequency, kHz |
| sys_khz_o | output | KHZ_W | System clock frequency, kHz |
| usb_khz_o | output | KHZ_W | USB clock frequency, kHz |

## Verification
A field write shows on the outputs just after the edge that samples it. The external ready flag rises XOSC_START_CYC edges after that edge. The PLL flag rises PLL_LOCK_CYC counted edges after its enable, and the count waits for the external flag when the reference is external. A source switch lands on the first edge after the request at which the source is ready, so the flags and the switch always differ by one edge.

The bench keeps a behavioural model that it advances at each rising edge. It compares every output with that model 5 ns later, after the edge has settled. The directed checks sample at falling edges, away from any update.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
  typedef enum logic [1:0] {
    SRC_FINT = 2'd0,
    SRC_FEXT = 2'd1,
    SRC_PLL  = 2'd2
  } sys_src_e;

  typedef enum logic [1:0] {
    REF_FINT_HALF = 2'd0,
    REF_FEXT      = 2'd1,
    REF_FEXT_HALF = 2'd2
  } pll_ref_e;

  typedef struct packed {
    pll_ref_e   ref_sel;
    logic [3:0] mul_code;
  } pll_cfg_t;

  localparam logic [2:0] A_ENABLE = 3'd0;
  localparam logic [2:0] A_PLLCFG = 3'd1;
  localparam logic [2:0] A_SYSREQ = 3'd2;
  localparam logic [2:0] A_RTCSEL = 3'd3;
  localparam logic [2:0] A_USBPRE = 3'd4;
endpackage

// File: rtl/clk_seq_ready_timer.sv
module clk_seq_ready_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  output logic rdy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (run_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // masking by enable drops the flag in the cycle after a disable
  assign rdy_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/clk_seq_src_switch.sv
module clk_seq_src_switch
  import clk_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_we_i,
  input  logic [1:0] req_i,
  input  logic       fext_rdy_i,
  input  logic       pll_rdy_i,
  output sys_src_e   act_o
);
  sys_src_e req_q, act_q;
  logic     req_rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        req_q <= SRC_FINT;
    else if (req_we_i && req_i != 2'd3) req_q <= sys_src_e'(req_i);
  end

  always_comb begin
    unique case (req_q)
      SRC_FEXT: req_rdy = fext_rdy_i;
      SRC_PLL:  req_rdy = pll_rdy_i;
      default:  req_rdy = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      act_q <= SRC_FINT;
    else if (req_rdy) act_q <= req_q;
  end

  assign act_o = act_q;
endmodule

// File: rtl/clk_seq_freq.sv
module clk_seq_freq
  import clk_seq_pkg::*;
#(
  parameter int unsigned FINT_KHZ    = 8000,
  parameter int unsigned FEXT_KHZ    = 8000,
  parameter int unsigned PLL_MAX_KHZ = 72000,
  parameter int unsigned KHZ_W       = 18
) (
  input  pll_cfg_t         cfg_i,
  input  sys_src_e         act_i,
  input  logic             usb_div15_i,
  output logic [4:0]       mul_o,
  output logic             pll_bad_o,
  output logic [KHZ_W-1:0] pll_khz_o,
  output logic [KHZ_W-1:0] sys_khz_o,
  output logic [KHZ_W-1:0] usb_khz_o
);
  localparam int unsigned FINT_HALF = FINT_KHZ / 2;
  localparam int unsigned FEXT_HALF = FEXT_KHZ / 2;

  int unsigned ref_k, pll_k, sys_k, usb_k;
  logic [4:0]  mul;

  always_comb begin
    unique case (cfg_i.ref_sel)
      REF_FINT_HALF: ref_k = FINT_HALF;
      REF_FEXT:      ref_k = FEXT_KHZ;
      default:       ref_k = FEXT_HALF;
    endcase
    mul   = (cfg_i.mul_code == 4'd15) ? 5'd16 : ({1'b0, cfg_i.mul_code} + 5'd2);
    pll_k = ref_k * 32'(mul);
    unique case (act_i)
      SRC_FEXT: sys_k = FEXT_KHZ;
      SRC_PLL:  sys_k = pll_k;
      default:  sys_k = FINT_KHZ;
    endcase
    usb_k = usb_div15_i ? (pll_k * 2) / 3 : pll_k;
  end

  assign mul_o     = mul;
  assign pll_bad_o = pll_k > PLL_MAX_KHZ;
  assign pll_khz_o = KHZ_W'(pll_k);
  assign sys_khz_o = KHZ_W'(sys_k);
  assign usb_khz_o = KHZ_W'(usb_k);
endmodule

// File: rtl/clk_seq_top.sv
module clk_seq_top
  import clk_seq_pkg::*;
#(
  parameter int unsigned FINT_KHZ       = 8000,
  parameter int unsigned FEXT_KHZ       = 8000,
  parameter int unsigned PLL_MAX_KHZ    = 72000,
  parameter int unsigned XOSC_START_CYC = 64,
  parameter int unsigned PLL_LOCK_CYC   = 32,
  parameter int unsigned KHZ_W          = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [5:0]       wr_data_i,
  output logic             xosc_rdy_o,
  output logic             pll_rdy_o,
  output logic [1:0]       sys_sel_o,
  output logic [3:0]       sws_o,
  output logic [1:0]       rtc_sel_o,
  output logic [1:0]       pll_ref_o,
  output logic [4:0]       pll_mul_o,
  output logic             pll_bad_o,
  output logic [KHZ_W-1:0] pll_khz_o,
  output logic [KHZ_W-1:0] sys_khz_o,
  output logic [KHZ_W-1:0] usb_khz_o
);
  logic     xosc_en_q, pll_en_q, usb_div15_q;
  logic     [1:0] rtc_q;
  pll_cfg_t cfg_q;
  sys_src_e act;
  logic     pll_ext_ref, xosc_hold, pll_hold, pll_run;
  logic     we_en, we_cfg, we_req, we_rtc, we_usb;

  assign we_en  = wr_i && wr_addr_i == A_ENABLE;
  assign we_cfg = wr_i && wr_addr_i == A_PLLCFG;
  assign we_req = wr_i && wr_addr_i == A_SYSREQ;
  assign we_rtc = wr_i && wr_addr_i == A_RTCSEL;
  assign we_usb = wr_i && wr_addr_i == A_USBPRE;

  assign pll_ext_ref = cfg_q.ref_sel != REF_FINT_HALF;
  // sources in use refuse to turn off
  assign xosc_hold = xosc_en_q && (act == SRC_FEXT || (pll_en_q && pll_ext_ref));
  assign pll_hold  = pll_en_q && act == SRC_PLL;
  assign pll_run   = !pll_ext_ref || xosc_rdy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xosc_en_q <= 1'b0;
      pll_en_q  <= 1'b0;
    end else if (we_en) begin
      xosc_en_q <= wr_data_i[0] | xosc_hold;
      pll_en_q  <= (wr_data_i[1] & ~pll_bad_o) | pll_hold;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{ref_sel: REF_FINT_HALF, mul_code: 4'd0};
    end else if (we_cfg && !pll_en_q && wr_data_i[1:0] != 2'd3) begin
      cfg_q <= '{ref_sel: pll_ref_e'(wr_data_i[1:0]), mul_code: wr_data_i[5:2]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtc_q       <= 2'd0;
      usb_div15_q <= 1'b0;
    end else begin
      if (we_rtc) rtc_q       <= wr_data_i[1:0];
      if (we_usb) usb_div15_q <= wr_data_i[0];
    end
  end

  clk_seq_ready_timer #(.CYCLES(XOSC_START_CYC)) u_xosc_tmr (
    .clk_i, .rst_ni, .en_i(xosc_en_q), .run_i(1'b1), .rdy_o(xosc_rdy_o)
  );

  clk_seq_ready_timer #(.CYCLES(PLL_LOCK_CYC)) u_pll_tmr (
    .clk_i, .rst_ni, .en_i(pll_en_q), .run_i(pll_run), .rdy_o(pll_rdy_o)
  );

  clk_seq_src_switch u_switch (
    .clk_i, .rst_ni,
    .req_we_i  (we_req),
    .req_i     (wr_data_i[1:0]),
    .fext_rdy_i(xosc_rdy_o),
    .pll_rdy_i (pll_rdy_o),
    .act_o     (act)
  );

  clk_seq_freq #(
    .FINT_KHZ(FINT_KHZ), .FEXT_KHZ(FEXT_KHZ),
    .PLL_MAX_KHZ(PLL_MAX_KHZ), .KHZ_W(KHZ_W)
  ) u_freq (
    .cfg_i      (cfg_q),
    .act_i      (act),
    .usb_div15_i(usb_div15_q),
    .mul_o      (pll_mul_o),
    .pll_bad_o  (pll_bad_o),
    .pll_khz_o  (pll_khz_o),
    .sys_khz_o  (sys_khz_o),
    .usb_khz_o  (usb_khz_o)
  );

  assign sys_sel_o = act;
  assign sws_o     = {act, 2'b00};
  assign rtc_sel_o = rtc_q;
  assign pll_ref_o = cfg_q.ref_sel;
endmodule

// File: rtl/clk_seq_chk.sv
module clk_seq_chk #(
  parameter int unsigned KHZ_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xosc_rdy_i,
  input logic             pll_rdy_i,
  input logic [1:0]       sys_sel_i,
  input logic [3:0]       sws_i,
  input logic [1:0]       pll_ref_i,
  input logic [KHZ_W-1:0] pll_khz_i,
  input logic             pll_bad_i
);
  p_pll_active_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_sel_i == 2'd2 |-> pll_rdy_i);

  p_ext_active_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_sel_i == 2'd1 |-> xosc_rdy_i);

  p_cfg_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rdy_i && $past(pll_rdy_i) |-> $stable(pll_khz_i));

  p_ext_ref_needs_xosc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rdy_i && pll_ref_i != 2'd0 |-> xosc_rdy_i);

  p_bad_never_locks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_bad_i |-> !pll_rdy_i);

  p_sws_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sws_i));

  p_sws_pll_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sws_i == 4'h8 |-> pll_rdy_i);
endmodule

bind clk_seq_top clk_seq_chk #(.KHZ_W(KHZ_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .xosc_rdy_i(xosc_rdy_o),
  .pll_rdy_i (pll_rdy_o),
  .sys_sel_i (sys_sel_o),
  .sws_i     (sws_o),
  .pll_ref_i (pll_ref_o),
  .pll_khz_i (pll_khz_o),
  .pll_bad_i (pll_bad_o)
);

// File: tb/tb_clk_seq_top.sv
module tb_clk_seq_top;
  localparam int FI = 8000, FE = 12000, PMAX = 72000, XN = 5, PN = 3, KW = 18;

  logic clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [5:0] wr_data_i = '0;
  logic xosc_rdy_o, pll_rdy_o, pll_bad_o;
  logic [1:0] sys_sel_o, rtc_sel_o, pll_ref_o;
  logic [3:0] sws_o;
  logic [4:0] pll_mul_o;
  logic [KW-1:0] pll_khz_o, sys_khz_o, usb_khz_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, run_cmp = 0;

  always #10 clk = ~clk;

  clk_seq_top #(.FINT_KHZ(FI), .FEXT_KHZ(FE), .PLL_MAX_KHZ(PMAX),
                .XOSC_START_CYC(XN), .PLL_LOCK_CYC(PN), .KHZ_W(KW)) dut (
    .clk_i(clk), .rst_ni, .wr_i, .wr_addr_i, .wr_data_i,
    .xosc_rdy_o, .pll_rdy_o, .sys_sel_o, .sws_o, .rtc_sel_o,
    .pll_ref_o, .pll_mul_o, .pll_bad_o, .pll_khz_o, .sys_khz_o, .usb_khz_o);

  // behavioural reference
  int m_xen, m_pen, m_xc, m_pc, m_ref, m_code, m_req, m_act, m_rtc, m_usb;

  function automatic int f_mul(int code);
    return (code + 2 > 16) ? 16 : code + 2;
  endfunction
  function automatic int f_pll(int r, int code);
    int base = (r == 0) ? FI / 2 : (r == 1) ? FE : FE / 2;
    return base * f_mul(code);
  endfunction
  function automatic int x_rdy(); return (m_xen != 0 && m_xc >= XN) ? 1 : 0; endfunction
  function automatic int p_rdy(); return (m_pen != 0 && m_pc >= PN) ? 1 : 0; endfunction
  function automatic int e_sys();
    return (m_act == 1) ? FE : (m_act == 2) ? f_pll(m_ref, m_code) : FI;
  endfunction
  function automatic int e_usb();
    return m_usb != 0 ? f_pll(m_ref, m_code) * 2 / 3 : f_pll(m_ref, m_code);
  endfunction

  always @(posedge clk or negedge rst_ni) begin : model
    int xr, pr, bad, nxc, npc, nact, nxen, npen, hx, hp, d;
    if (!rst_ni) begin
      m_xen = 0; m_pen = 0; m_xc = 0; m_pc = 0; m_ref = 0; m_code = 0;
      m_req = 0; m_act = 0; m_rtc = 0; m_usb = 0;
    end else begin
      xr = x_rdy(); pr = p_rdy();
      bad = (f_pll(m_ref, m_code) > PMAX) ? 1 : 0;
      nxc = m_xen != 0 ? ((m_xc + 1 > XN) ? XN : m_xc + 1) : 0;
      npc = m_pc;
      if (m_pen == 0) npc = 0;
      else if (m_ref == 0 || xr != 0) npc = (m_pc + 1 > PN) ? PN : m_pc + 1;
      nact = m_act;
      if (m_req == 0 || (m_req == 1 && xr != 0) || (m_req == 2 && pr != 0)) nact = m_req;
      nxen = m_xen; npen = m_pen;
      d = int'(wr_data_i);
      if (wr_i) begin
        case (int'(wr_addr_i))
          0: begin
            hx = (m_xen != 0 && (m_act == 1 || (m_pen != 0 && m_ref != 0))) ? 1 : 0;
            hp = (m_pen != 0 && m_act == 2) ? 1 : 0;
            nxen = ((d & 1) != 0 || hx != 0) ? 1 : 0;
            npen = (((d & 2) != 0 && bad == 0) || hp != 0) ? 1 : 0;
          end
          1: if (m_pen == 0 && (d & 3) != 3) begin m_ref = d & 3; m_code = d >> 2; end
          2: if ((d & 3) != 3) m_req = d & 3;
          3: m_rtc = d & 3;
          4: m_usb = d & 1;
          default: ;
        endcase
      end
      if (nxen == 0) nxc = 0;
      if (npen == 0) npc = 0;
      m_xen = nxen; m_pen = npen; m_xc = nxc; m_pc = npc; m_act = nact;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_ni && run_cmp) begin
      chk("R2 xosc_rdy", int'(xosc_rdy_o), x_rdy());
      chk("R3 pll_rdy", int'(pll_rdy_o), p_rdy());
      chk("R7 sys_sel", int'(sys_sel_o), m_act);
      chk("R8 sws", int'(sws_o), m_act * 4);
      chk("R10 rtc_sel", int'(rtc_sel_o), m_rtc);
      chk("R5 pll_ref", int'(pll_ref_o), m_ref);
      chk("R5 pll_mul", int'(pll_mul_o), f_mul(m_code));
      chk("R5 pll_khz", int'(pll_khz_o), f_pll(m_ref, m_code));
      chk("R6 pll_bad", int'(pll_bad_o), (f_pll(m_ref, m_code) > PMAX) ? 1 : 0);
      chk("R12 sys_khz", int'(sys_khz_o), e_sys());
      chk("R11 usb_khz", int'(usb_khz_o), e_usb());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 6'(d);
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sys_sel", int'(sys_sel_o), 0);
    chk("R1 sws", int'(sws_o), 0);
    chk("R1 xosc_rdy", int'(xosc_rdy_o), 0);
    chk("R1 pll_rdy", int'(pll_rdy_o), 0);
    chk("R1 rtc_sel", int'(rtc_sel_o), 0);
    chk("R1 pll_ref", int'(pll_ref_o), 0);
    chk("R1 pll_mul", int'(pll_mul_o), 2);
    rst_ni = 1'b1; run_cmp = 1;
    idle(2);
    wr(3, 3); wr(3, 1);                 // R10
    wr(2, 1); idle(4);                  // R7 request held, external off
    chk("R7 held on internal", int'(sys_sel_o), 0);
    wr(0, 1); idle(8);                  // R2 start-up, then switch lands
    chk("R7 switched to external", int'(sys_sel_o), 1);
    wr(1, (5 << 2) | 1);                // 12000*7 over limit
    wr(0, 3); idle(8);
    chk("R6 enable refused", int'(pll_rdy_o), 0);
    wr(1, (4 << 2) | 1);                // 72000
    wr(0, 3); idle(1);
    wr(1, (14 << 2) | 0);               // ignored while enabled
    chk("R4 cfg frozen", int'(pll_khz_o), 72000);
    idle(6);
    wr(2, 2); idle(3);
    chk("R8 pll status", int'(sws_o), 8);
    wr(4, 1); idle(2);
    chk("R11 usb 1.5", int'(usb_khz_o), 48000);
    wr(4, 0);
    wr(0, 0); idle(3);                  // active PLL and its reference stay on
    chk("R9 pll kept", int'(pll_rdy_o), 1);
    chk("R9 xosc kept", int'(xosc_rdy_o), 1);
    wr(2, 3); idle(2);
    chk("R7 code 3 ignored", int'(sys_sel_o), 2);
    wr(2, 0); idle(2);
    wr(0, 0); idle(2);                  // PLL off, xosc held by the earlier PLL state
    wr(0, 0); idle(2);
    chk("R2 xosc off", int'(xosc_rdy_o), 0);
    wr(1, 3); idle(1);
    chk("R4 ref code 3 ignored", int'(pll_ref_o), 1);
    wr(1, (10 << 2) | 2);               // 6000*12
    wr(0, 2); idle(10);
    chk("R3 waits for reference", int'(pll_rdy_o), 0);
    wr(0, 3); idle(12);
    chk("R3 locked after reference", int'(pll_rdy_o), 1);
    wr(2, 2); idle(3);
    wr(2, 1); idle(3);
    chk("R12 external frequency", int'(sys_khz_o), FE);
    wr(2, 0); idle(2);
    wr(0, 0); idle(2); wr(0, 0); idle(2);
    wr(1, (15 << 2) | 0); idle(2);
    chk("R5 multiplier capped", int'(pll_khz_o), 64000);
    wr(0, 2); idle(6);
    wr(0, 0); idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule